// File: doc/BRIEF.md
# Zero-Steered Adder Selector

This block is a behavioural, synthesizable model of the post-adder stage of an arithmetic slice, used as a wide 48-bit selector. Four operand selectors (W, X, Y, Z) each pick either a data source or zero. Their outputs are summed and the sum is registered onto the output. A source is chosen by steering every selector but one to zero, so the sum equals that one source. No separate select line is needed.

A 30-bit word and an 18-bit word are registered and joined into one 48-bit word, with the 30-bit word in the upper bits. A third 48-bit word is also registered. The 9-bit operation code and 4-bit ALU code pass through a control register stage with the same depth. As a result, data and control that arrive together reach the output together, two clock edges later. The multiplier, pre-adder, cascades, carry logic, SIMD splitting and pattern detection are not modelled.

Top module: `wide_addsel`

## Requirements
- R1: When the operation code is 9'h003, the output equals the registered joined word, with `a_in` as bits 47:18 and `b_in` as bits 17:0.
- R2: When the operation code is 9'h00C, the output equals the registered `c_in`.
- R3: Operation-code bits 6:4 equal to 3'b011 add `c_in` through the Z selector (for example, 9'h030 gives `c_in`). Any other value of bits 6:4 makes Z contribute zero.
- R4: Bits 1:0 other than 2'b11 make X zero, and bits 3:2 other than 2'b11 make Y zero. The W selector contributes zero for every value of bits 8:7.
- R5: With the ALU code at zero, the output is the sum of all selector outputs, modulo 2^48, with no carry out. For example, 9'h03F gives joined word + 2·C.
- R6: A change on any data or control input appears at `p_out` after exactly two rising clock edges.
- R7: A synchronous reset clears every register stage. `p_out` reads zero while reset is held and for the first cycle after it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 30 | Upper part of the joined word |
| b_in | input | 18 | Lower part of the joined word |
| c_in | input | 48 | Second data word, reachable through Y and Z |
| opmode_in | input | 9 | Operation code steering the W/X/Y/Z selectors |
| alumode_in | input | 4 | ALU code; zero means add |
| p_out | output | 48 | Registered sum |

## Verification
Directed vectors pass all-ones in only the upper or only the lower field of the joined word, which exposes a swapped or shifted concatenation. Single-selector codes for X, Y and Z are followed by codes that differ from a selecting code in one bit, including the W field, so a selector that decodes too loosely produces a nonzero sum. Combined codes with all-ones operands force wrap-around, which separates a true modulo-2^48 sum from one that saturates or leaks a carry. Random codes and data are streamed every cycle and checked two cycles later, which catches any extra or missing pipeline stage. A reset in the middle of the run checks that every stage is cleared.

// File: rtl/addsel_pkg.sv
package addsel_pkg;
  // selector codes decoded by the operand stage
  localparam logic [1:0] XCODE_AB = 2'b11;
  localparam logic [1:0] YCODE_C  = 2'b11;
  localparam logic [2:0] ZCODE_C  = 3'b011;

  // field positions inside the operation code
  localparam int X_LSB = 0;
  localparam int Y_LSB = 2;
  localparam int Z_LSB = 4;
  localparam int W_LSB = 7;

  typedef struct packed {
    logic [1:0] x;
    logic [1:0] y;
    logic [2:0] z;
    logic [1:0] w;
  } opfields_t;

  function automatic opfields_t split_op(input logic [8:0] op);
    opfields_t f;
    f.x = op[X_LSB +: 2];
    f.y = op[Y_LSB +: 2];
    f.z = op[Z_LSB +: 3];
    f.w = op[W_LSB +: 2];
    return f;
  endfunction
endpackage

// File: rtl/addsel_reg.sv
module addsel_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/addsel_opsel.sv
module addsel_opsel #(
  parameter int A_W  = 30,
  parameter int B_W  = 18,
  parameter int OP_W = 9
) (
  input  logic [A_W+B_W-1:0] ab,
  input  logic [A_W+B_W-1:0] c,
  input  logic [OP_W-1:0]    op,
  output logic [A_W+B_W-1:0] w_opnd,
  output logic [A_W+B_W-1:0] x_opnd,
  output logic [A_W+B_W-1:0] y_opnd,
  output logic [A_W+B_W-1:0] z_opnd
);
  import addsel_pkg::*;

  opfields_t f;
  logic      unused_wfield;

  always_comb begin
    f = split_op(op[8:0]);
    x_opnd = (f.x == XCODE_AB) ? ab : '0;
    y_opnd = (f.y == YCODE_C)  ? c  : '0;
    z_opnd = (f.z == ZCODE_C)  ? c  : '0;
    // reduced model: every W code selects zero
    w_opnd = '0;
  end

  assign unused_wfield = ^f.w;
endmodule

// File: rtl/addsel_sum.sv
module addsel_sum #(
  parameter int P_W   = 48,
  parameter int ALU_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [P_W-1:0]   w_opnd,
  input  logic [P_W-1:0]   x_opnd,
  input  logic [P_W-1:0]   y_opnd,
  input  logic [P_W-1:0]   z_opnd,
  input  logic [ALU_W-1:0] alu,
  output logic [P_W-1:0]   p
);
  logic [P_W-1:0] sum_wx;
  logic [P_W-1:0] sum_yz;
  logic [P_W-1:0] total;
  logic           unused_alu;

  // balanced two-level add tree, truncated to P_W bits
  always_comb begin
    sum_wx = w_opnd + x_opnd;
    sum_yz = y_opnd + z_opnd;
    total  = sum_wx + sum_yz;
  end

  // every ALU code is treated as add in this model
  assign unused_alu = ^alu;

  always_ff @(posedge clk) begin
    if (rst) p <= '0;
    else     p <= total;
  end
endmodule

// File: rtl/wide_addsel.sv
module wide_addsel #(
  parameter int A_W   = 30,
  parameter int B_W   = 18,
  parameter int OP_W  = 9,
  parameter int ALU_W = 4,
  localparam int P_W  = A_W + B_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  input  logic [P_W-1:0]   c_in,
  input  logic [OP_W-1:0]  opmode_in,
  input  logic [ALU_W-1:0] alumode_in,
  output logic [P_W-1:0]   p_out
);
  logic [A_W-1:0]   a_q;
  logic [B_W-1:0]   b_q;
  logic [P_W-1:0]   c_q;
  logic [OP_W-1:0]  op_q;
  logic [ALU_W-1:0] alu_q;
  logic [P_W-1:0]   ab_q;
  logic [P_W-1:0]   w_s, x_s, y_s, z_s;

  addsel_reg #(.WIDTH(A_W))   a_reg_i   (.clk(clk), .rst(rst), .d(a_in),       .q(a_q));
  addsel_reg #(.WIDTH(B_W))   b_reg_i   (.clk(clk), .rst(rst), .d(b_in),       .q(b_q));
  addsel_reg #(.WIDTH(P_W))   c_reg_i   (.clk(clk), .rst(rst), .d(c_in),       .q(c_q));
  addsel_reg #(.WIDTH(OP_W))  op_reg_i  (.clk(clk), .rst(rst), .d(opmode_in),  .q(op_q));
  addsel_reg #(.WIDTH(ALU_W)) alu_reg_i (.clk(clk), .rst(rst), .d(alumode_in), .q(alu_q));

  assign ab_q = {a_q, b_q};

  addsel_opsel #(.A_W(A_W), .B_W(B_W), .OP_W(OP_W)) opsel_i (
    .ab(ab_q), .c(c_q), .op(op_q),
    .w_opnd(w_s), .x_opnd(x_s), .y_opnd(y_s), .z_opnd(z_s)
  );

  addsel_sum #(.P_W(P_W), .ALU_W(ALU_W)) sum_i (
    .clk(clk), .rst(rst),
    .w_opnd(w_s), .x_opnd(x_s), .y_opnd(y_s), .z_opnd(z_s),
    .alu(alu_q), .p(p_out)
  );
endmodule

// File: rtl/wide_addsel_chk.sv
module wide_addsel_chk #(
  parameter int A_W   = 30,
  parameter int B_W   = 18,
  parameter int OP_W  = 9,
  parameter int ALU_W = 4,
  localparam int P_W  = A_W + B_W
) (
  input logic             clk,
  input logic             rst,
  input logic [A_W-1:0]   a_in,
  input logic [B_W-1:0]   b_in,
  input logic [P_W-1:0]   c_in,
  input logic [OP_W-1:0]  opmode_in,
  input logic [ALU_W-1:0] alumode_in,
  input logic [P_W-1:0]   p_out
);
  // counts clean edges after reset; pipeline is full once it reaches 2
  logic [1:0] warm_cnt;
  always_ff @(posedge clk) begin
    if (rst)                 warm_cnt <= '0;
    else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
  end

  logic warm;
  assign warm = (warm_cnt == 2'd2);

  a_r1_ab_pass: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(opmode_in, 2) == 9'h003 && $past(alumode_in, 2) == '0)
      |-> p_out == $past({a_in, b_in}, 2));

  a_r2_c_pass: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(opmode_in, 2) == 9'h00C && $past(alumode_in, 2) == '0)
      |-> p_out == $past(c_in, 2));

  a_r3_z_pass: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(opmode_in, 2) == 9'h030 && $past(alumode_in, 2) == '0)
      |-> p_out == $past(c_in, 2));

  a_r4_all_zero: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(opmode_in[1:0], 2) != 2'b11 && $past(opmode_in[3:2], 2) != 2'b11
          && $past(opmode_in[6:4], 2) != 3'b011)
      |-> p_out == '0);

  a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> p_out == '0);
endmodule

bind wide_addsel wide_addsel_chk #(
  .A_W(A_W), .B_W(B_W), .OP_W(OP_W), .ALU_W(ALU_W)
) chk_i (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
  .opmode_in(opmode_in), .alumode_in(alumode_in), .p_out(p_out)
);

// File: tb/wide_addsel_tb_top.sv
`timescale 1ns/1ps
module wide_addsel_tb_top;
  localparam int A_W = 30, B_W = 18, OP_W = 9, ALU_W = 4, P_W = A_W + B_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [A_W-1:0]   a_in = '0;
  logic [B_W-1:0]   b_in = '0;
  logic [P_W-1:0]   c_in = '0;
  logic [OP_W-1:0]  opmode_in = '0;
  logic [ALU_W-1:0] alumode_in = '0;
  logic [P_W-1:0]   p_out;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  wide_addsel #(.A_W(A_W), .B_W(B_W), .OP_W(OP_W), .ALU_W(ALU_W)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .opmode_in(opmode_in), .alumode_in(alumode_in), .p_out(p_out)
  );

  // pending expectations: slot0 = one cycle old, slot1 = two cycles old
  logic [P_W-1:0] exp0, exp1;
  string          tag0, tag1;
  bit             v0, v1;

  function automatic logic [P_W-1:0] model(input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                                           input logic [P_W-1:0] c, input logic [OP_W-1:0] op);
    logic [P_W-1:0] x, y, z;
    x = (op[1:0] == 2'b11) ? {a, b} : '0;
    y = (op[3:2] == 2'b11) ? c : '0;
    z = (op[6:4] == 3'b011) ? c : '0;
    return x + y + z;
  endfunction

  task automatic check(input string tag, input logic [P_W-1:0] act, input logic [P_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: p_out=%012h expected=%012h", tag, act, exp);
    end
  endtask

  // one cycle: check result due now, then drive new vector
  task automatic step(input string tag, input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                      input logic [P_W-1:0] c, input logic [OP_W-1:0] op);
    @(negedge clk);
    if (v1) check(tag1, p_out, exp1);
    exp1 = exp0; tag1 = tag0; v1 = v0;
    exp0 = model(a, b, c, op); tag0 = tag; v0 = 1'b1;
    a_in = a; b_in = b; c_in = c; opmode_in = op; alumode_in = '0;
  endtask

  task automatic flush();
    step("R4 flush", '0, '0, '0, 9'h000);
    step("R4 flush", '0, '0, '0, 9'h000);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    a_in = '1; b_in = '1; c_in = '1; opmode_in = 9'h03F;
    v0 = 1'b0; v1 = 1'b0;
    @(negedge clk);
    check("R7 held", p_out, '0);
    @(negedge clk);
    check("R7 held", p_out, '0);
    rst = 1'b0;  // data and code stay selecting
    @(negedge clk);
    check("R7 first cycle after release", p_out, '0);
    exp0 = model('1, '1, '1, 9'h03F); tag0 = "R6 after reset"; v0 = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [P_W-1:0] dummy;
    void'($urandom(32'h5eed_1234));
    v0 = 1'b0; v1 = 1'b0;
    do_reset();

    // R1: field placement of the joined word
    step("R1 upper", '1, '0, 48'h1234_5678_9abc, 9'h003);
    step("R1 lower", '0, '1, 48'h1234_5678_9abc, 9'h003);
    step("R1 mix", 30'h2aaa_aaaa, 18'h15555, '1, 9'h003);
    // R2 / R3
    step("R2 c via Y", '1, '1, 48'hdead_beef_0001, 9'h00C);
    step("R3 c via Z", '1, '1, 48'h0f0f_f0f0_5a5a, 9'h030);
    step("R3 Z code 010", '1, '1, '1, 9'h020);
    step("R3 Z code 111", '1, '1, '1, 9'h070);
    // R4: near-miss codes and W field
    step("R4 X code 01", '1, '1, '1, 9'h001);
    step("R4 X code 10", '1, '1, '1, 9'h002);
    step("R4 Y code 10", '1, '1, '1, 9'h008);
    step("R4 W field", '1, '1, '1, 9'h180);
    step("R4 W field", '1, '1, '1, 9'h080);
    // R5: sums and wrap
    step("R5 wrap X+Y", '1, '1, 48'h1, 9'h00F);
    step("R5 X+Y+Z", 30'h1, 18'h2, 48'h10, 9'h03F);
    step("R5 wrap 3 terms", '1, '1, '1, 9'h03F);
    step("R5 Y+Z", '0, '0, 48'h8000_0000_0000, 9'h03C);
    flush();

    // R6: streamed random vectors, each checked two cycles later
    for (int i = 0; i < 400; i++) begin
      logic [OP_W-1:0] op;
      case ($urandom_range(0, 5))
        0: op = 9'h003;
        1: op = 9'h00C;
        2: op = 9'h030;
        3: op = 9'h03F;
        4: op = 9'h000;
        default: op = OP_W'($urandom);
      endcase
      step("R6 stream", A_W'($urandom), B_W'($urandom), {16'($urandom), 32'($urandom)}, op);
    end
    flush();

    // R7: reset in the middle of traffic
    do_reset();
    step("R6 post-reset", 30'h1, 18'h0, '0, 9'h003);
    flush();

    dummy = '0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule